// File: doc/BRIEF.md
# Calibration Mode Sequencer

This block sits between a converter's control register and its measurement engine. It reads the three-bit operating mode and the channel select. It then runs the matching series of measurement steps: plain conversions, zero-scale steps or full-scale steps. Each step is taken from the selected input, from internally shorted inputs or from the reference. The engine is abstract. The sequencer raises a request that stays up until the engine answers with a one-cycle done pulse, and the analog side and the coefficient arithmetic live elsewhere.

When a step finishes that makes a result available, the sequencer drives its active-low ready output low. When a one-shot calibration completes, it also pulses a mode-clear strobe so that the register block writes the mode field back to normal, and the sequencer itself drops back to continuous conversions. Background mode never clears itself. It interleaves calibration measurements with conversions on a fixed slot schedule, so only one slot in every schedule length produces a data result. The two coefficient-access modes start no measurement and only steer which register the address-high port reaches.

Top module: `cal_mode_sequencer`

## Requirements
- R1: After reset, readyN is 1, measReq is 0, modeClear is 0 and regSel is 0. The active mode is normal (code 000), so the first request is a conversion (measKind 0) from the selected input (measSrc 0).
- R2: In mode 000, each request is one conversion step with measKind 0 and measSrc 0. Every completed step drives readyN low, modeClear never pulses, and a new request follows.
- R3: Mode 001 makes two requests: zero-scale (measKind 1) from shorted inputs (measSrc 1), then full-scale (measKind 2) from the reference (measSrc 2). readyN goes low only after the second step, and the mode then returns to 000.
- R4: Mode 010 makes a single zero-scale request (measKind 1) and mode 011 a single full-scale request (measKind 2), both from the selected input (measSrc 0). Each then drives readyN low and returns to 000.
- R5: Mode 100 makes a zero-scale request from the selected input (measKind 1, measSrc 0), then a full-scale request from the reference (measKind 2, measSrc 2). readyN goes low after the second step, and the mode returns to 000.
- R6: Mode 101 repeats a schedule of BG_SLOTS steps. Slot 0 and every even slot before the last is zero-scale on shorted inputs, and every odd slot before the last is full-scale on the reference. The last slot is a conversion from the input. readyN goes low only after the last slot, the schedule wraps to slot 0, and the mode never clears.
- R7: Modes 110 and 111 raise no request and leave readyN unchanged. They set regSel to 1 (zero-scale coefficients) and 2 (full-scale coefficients) respectively. In every other mode regSel is 0 (data register).
- R8: Once raised, measReq stays high until a cycle with measDone, and it is low in the following cycle. A measDone while no request is pending has no effect. measChan holds the chanSel value sampled when the request rose, for as long as the request lasts.
- R9: readyN returns to 1 on readStrobe and on a mode write of any code that starts a sequence (000 to 101). If a completion and readStrobe fall in the same cycle, the completion wins and readyN goes low.
- R10: A mode write (modeWrEn) aborts any running step. measReq is low in the next cycle, the new mode starts from its first step, and a measDone in the same cycle as the write is ignored.
- R11: modeClear is a single-cycle pulse that occurs exactly when readyN falls at the end of modes 001, 010, 011 and 100, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWrEn | input | 1 | One-cycle strobe: control register mode field written |
| modeWrData | input | 3 | New mode code |
| chanSel | input | CHAN_W | Channel select from the control register |
| readStrobe | input | 1 | Result has been read; releases ready |
| measDone | input | 1 | Measurement engine finished the requested step |
| measReq | output | 1 | Step request to the measurement engine, held until done |
| measKind | output | 2 | Step kind: 0 conversion, 1 zero-scale, 2 full-scale |
| measSrc | output | 2 | Source: 0 selected input, 1 shorted inputs, 2 reference |
| measChan | output | CHAN_W | Channel captured for the current step |
| readyN | output | 1 | Active-low result ready |
| modeClear | output | 1 | One-cycle strobe: write mode field back to normal |
| regSel | output | 2 | Register reached by the address-high port: 0 data, 1 zero coef, 2 full coef |

## Verification
The bench builds the block with CHAN_W = 2 and BG_SLOTS = 6. The two-bit channel lets four distinct channel values show up on measChan, which shows that the channel is captured at request time and not taken live. Six background slots are enough to exercise both calibration kinds and more than one alternation before the conversion slot, and with them the wrap back to slot 0 and the absence of a mode clear.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL   = 3'b000,
    MODE_SELF     = 3'b001,
    MODE_SYS_ZERO = 3'b010,
    MODE_SYS_FULL = 3'b011,
    MODE_SYS_OFFS = 3'b100,
    MODE_BACKGND  = 3'b101,
    MODE_ACC_ZERO = 3'b110,
    MODE_ACC_FULL = 3'b111
  } mode_e;

  typedef enum logic [1:0] {
    KIND_CONV = 2'd0,
    KIND_ZERO = 2'd1,
    KIND_FULL = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    SRC_INPUT     = 2'd0,
    SRC_SHORTED   = 2'd1,
    SRC_REFERENCE = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    REG_DATA      = 2'd0,
    REG_ZERO_COEF = 2'd1,
    REG_FULL_COEF = 2'd2
  } regsel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // take a newly written mode, restart at step 0
    logic start;    // a step request is being raised this cycle
    logic advance;  // the pending step completed
  } strobe_t;

  // decoded description of the current step
  typedef struct packed {
    logic  runs;    // current mode produces measurement steps
    logic  last;    // this step ends the sequence (result ready)
    logic  clears;  // sequence end writes the mode back to normal
    kind_e kind;
    src_e  src;
  } step_t;

endpackage

// File: rtl/calseq_path.sv
module calseq_path
  import calseq_pkg::*;
#(
  parameter int CHAN_W   = 1,
  parameter int BG_SLOTS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [MODE_W-1:0]   wrMode,
  input  logic [CHAN_W-1:0]   chanSel,
  output step_t               step,
  output logic                wrRuns,
  output logic [CHAN_W-1:0]   chanLat,
  output regsel_e             regSel
);

  localparam int IDX_W = (BG_SLOTS > 2) ? $clog2(BG_SLOTS) : 1;
  localparam logic [IDX_W-1:0] BG_LAST = IDX_W'(BG_SLOTS - 1);

  mode_e            curMode;
  logic [IDX_W-1:0] stepIdx;

  // mode and step position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMode <= MODE_NORMAL;
      stepIdx <= '0;
    end else if (strb.load) begin
      curMode <= mode_e'(wrMode);
      stepIdx <= '0;
    end else if (strb.advance) begin
      if (step.last) begin
        stepIdx <= '0;
        if (step.clears) curMode <= MODE_NORMAL;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  // channel captured when a request rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           chanLat <= '0;
    else if (strb.start) chanLat <= chanSel;
  end

  // step decode
  always_comb begin
    step.runs   = 1'b1;
    step.last   = 1'b1;
    step.clears = 1'b1;
    step.kind   = KIND_CONV;
    step.src    = SRC_INPUT;
    unique case (curMode)
      MODE_NORMAL: begin
        step.clears = 1'b0;
      end
      MODE_SELF: begin
        if (stepIdx == '0) begin
          step.last = 1'b0;
          step.kind = KIND_ZERO;
          step.src  = SRC_SHORTED;
        end else begin
          step.kind = KIND_FULL;
          step.src  = SRC_REFERENCE;
        end
      end
      MODE_SYS_ZERO: begin
        step.kind = KIND_ZERO;
      end
      MODE_SYS_FULL: begin
        step.kind = KIND_FULL;
      end
      MODE_SYS_OFFS: begin
        if (stepIdx == '0) begin
          step.last = 1'b0;
          step.kind = KIND_ZERO;
        end else begin
          step.kind = KIND_FULL;
          step.src  = SRC_REFERENCE;
        end
      end
      MODE_BACKGND: begin
        step.clears = 1'b0;
        if (stepIdx != BG_LAST) begin
          step.last = 1'b0;
          if (stepIdx[0] == 1'b0) begin
            step.kind = KIND_ZERO;
            step.src  = SRC_SHORTED;
          end else begin
            step.kind = KIND_FULL;
            step.src  = SRC_REFERENCE;
          end
        end
      end
      default: begin
        step.runs   = 1'b0;
        step.last   = 1'b0;
        step.clears = 1'b0;
      end
    endcase
  end

  // register steering for the address-high port
  always_comb begin
    unique case (curMode)
      MODE_ACC_ZERO: regSel = REG_ZERO_COEF;
      MODE_ACC_FULL: regSel = REG_FULL_COEF;
      default:       regSel = REG_DATA;
    endcase
  end

  // does a written code start a sequence
  always_comb begin
    wrRuns = !((wrMode == MODE_ACC_ZERO) || (wrMode == MODE_ACC_FULL));
  end

endmodule

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
  import calseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeWrEn,
  input  logic    wrRuns,
  input  logic    readStrobe,
  input  logic    measDone,
  input  logic    stepRuns,
  input  logic    stepLast,
  input  logic    stepClears,
  output strobe_t strb,
  output logic    measReq,
  output logic    readyN,
  output logic    modeClear
);

  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e state;

  always_comb begin
    strb.load    = modeWrEn;
    strb.start   = !modeWrEn && (state == ST_IDLE) && stepRuns;
    strb.advance = !modeWrEn && (state == ST_BUSY) && measDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             state <= ST_IDLE;
    else if (strb.load)    state <= ST_IDLE;
    else if (strb.start)   state <= ST_BUSY;
    else if (strb.advance) state <= ST_IDLE;
  end

  assign measReq = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyN    <= 1'b1;
      modeClear <= 1'b0;
    end else begin
      modeClear <= strb.advance && stepLast && stepClears;
      if (strb.advance && stepLast)                 readyN <= 1'b0;
      else if ((strb.load && wrRuns) || readStrobe) readyN <= 1'b1;
    end
  end

endmodule

// File: rtl/cal_mode_sequencer.sv
module cal_mode_sequencer
  import calseq_pkg::*;
#(
  parameter int CHAN_W   = 1,
  parameter int BG_SLOTS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [2:0]        modeWrData,
  input  logic [CHAN_W-1:0] chanSel,
  input  logic              readStrobe,
  input  logic              measDone,
  output logic              measReq,
  output logic [1:0]        measKind,
  output logic [1:0]        measSrc,
  output logic [CHAN_W-1:0] measChan,
  output logic              readyN,
  output logic              modeClear,
  output logic [1:0]        regSel
);

  strobe_t strb;
  step_t   step;
  logic    wrRuns;
  regsel_e regSelE;

  calseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .wrRuns     (wrRuns),
    .readStrobe (readStrobe),
    .measDone   (measDone),
    .stepRuns   (step.runs),
    .stepLast   (step.last),
    .stepClears (step.clears),
    .strb       (strb),
    .measReq    (measReq),
    .readyN     (readyN),
    .modeClear  (modeClear)
  );

  calseq_path #(.CHAN_W(CHAN_W), .BG_SLOTS(BG_SLOTS)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrMode  (modeWrData),
    .chanSel (chanSel),
    .step    (step),
    .wrRuns  (wrRuns),
    .chanLat (measChan),
    .regSel  (regSelE)
  );

  assign measKind = step.kind;
  assign measSrc  = step.src;
  assign regSel   = regSelE;

endmodule

// File: rtl/calseq_checker.sv
module calseq_checker #(
  parameter int CHAN_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeWrEn,
  input logic              readStrobe,
  input logic              measDone,
  input logic              measReq,
  input logic [CHAN_W-1:0] measChan,
  input logic              readyN,
  input logic              modeClear,
  input logic [1:0]        regSel
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    measReq && !measDone && !modeWrEn |=> measReq); // R8

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    measReq && measDone |=> !measReq); // R8

  AST_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    measReq && !measDone && !modeWrEn |=> $stable(measChan)); // R8

  AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    modeClear |=> !modeClear); // R11

  AST_CLEAR_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeClear) |-> $fell(readyN)); // R11

  AST_WR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> !measReq && !modeClear); // R10

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe && !(measReq && measDone && !modeWrEn) |=> readyN); // R9

  AST_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    regSel != 2'd0 |-> !measReq); // R7

endmodule

bind cal_mode_sequencer calseq_checker #(.CHAN_W(CHAN_W)) u_calseq_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrEn   (modeWrEn),
  .readStrobe (readStrobe),
  .measDone   (measDone),
  .measReq    (measReq),
  .measChan   (measChan),
  .readyN     (readyN),
  .modeClear  (modeClear),
  .regSel     (regSel)
);

// File: tb/cal_mode_sequencer_bench.sv
module cal_mode_sequencer_bench;

  localparam int CHAN_W   = 2;
  localparam int BG_SLOTS = 6;

  // one row: mode, step count, clears, step nibbles {kind,src}, step 0 in bits 3:0
  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  n;
    logic        clr;
    logic [23:0] seq;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{mode: 3'd0, n: 3'd1, clr: 1'b0, seq: 24'h000000},
    '{mode: 3'd1, n: 3'd2, clr: 1'b1, seq: 24'h0000A5},
    '{mode: 3'd2, n: 3'd1, clr: 1'b1, seq: 24'h000004},
    '{mode: 3'd3, n: 3'd1, clr: 1'b1, seq: 24'h000008},
    '{mode: 3'd4, n: 3'd2, clr: 1'b1, seq: 24'h0000A4},
    '{mode: 3'd5, n: 3'd6, clr: 1'b0, seq: 24'h05A5A5}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeWrEn = 1'b0;
  logic [2:0]        modeWrData = 3'd0;
  logic [CHAN_W-1:0] chanSel = '0;
  logic              readStrobe = 1'b0;
  logic              measDone = 1'b0;
  logic              measReq;
  logic [1:0]        measKind;
  logic [1:0]        measSrc;
  logic [CHAN_W-1:0] measChan;
  logic              readyN;
  logic              modeClear;
  logic [1:0]        regSel;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cal_mode_sequencer #(.CHAN_W(CHAN_W), .BG_SLOTS(BG_SLOTS)) u_cal_mode_sequencer (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .chanSel(chanSel), .readStrobe(readStrobe), .measDone(measDone),
    .measReq(measReq), .measKind(measKind), .measSrc(measSrc),
    .measChan(measChan), .readyN(readyN), .modeClear(modeClear), .regSel(regSel)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeMode(input logic [2:0] m, input logic [CHAN_W-1:0] ch);
    chanSel    = ch;
    modeWrData = m;
    modeWrEn   = 1'b1;
    @(negedge clk);
    modeWrEn   = 1'b0;
  endtask

  task automatic waitReq(input string req);
    for (int i = 0; i < 20 && !measReq; i++) @(negedge clk);
    chkEq(req, "measReq rises", int'(measReq), 1);
  endtask

  task automatic pulseRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic serviceStep(input int kind, input int src, input int ch, input string req);
    waitReq(req);
    chkEq(req, "measKind", int'(measKind), kind);
    chkEq(req, "measSrc", int'(measSrc), src);
    chkEq(req, "measChan", int'(measChan), ch);
    @(negedge clk);
    chkEq("R8", "measReq held", int'(measReq), 1);
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    chkEq("R8", "measReq drops after done", int'(measReq), 0);
  endtask

  function automatic string reqName(input logic [2:0] m);
    case (m)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R4";
      3'd4:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    vec_t v;
    string req;
    logic [3:0] nib;
    logic [CHAN_W-1:0] ch;

    // R1: reset state
    repeat (3) @(negedge clk);
    chkEq("R1", "readyN in reset", int'(readyN), 1);
    chkEq("R1", "measReq in reset", int'(measReq), 0);
    chkEq("R1", "modeClear in reset", int'(modeClear), 0);
    chkEq("R1", "regSel in reset", int'(regSel), 0);
    rstN = 1'b1;
    serviceStep(0, 0, 0, "R1");
    chkEq("R2", "readyN after conversion", int'(readyN), 0);
    pulseRead();
    chkEq("R9", "readyN after read", int'(readyN), 1);

    // table walk over the sequence modes
    for (int e = 0; e < 6; e++) begin
      v   = VEC[e];
      req = reqName(v.mode);
      ch  = CHAN_W'(e);
      writeMode(v.mode, ch);
      chkEq("R9", "readyN after mode write", int'(readyN), 1);
      chkEq("R10", "measReq after mode write", int'(measReq), 0);
      for (int k = 0; k < int'(v.n); k++) begin
        nib = v.seq[k*4 +: 4];
        serviceStep(int'(nib[3:2]), int'(nib[1:0]), int'(ch), req);
        if (k < int'(v.n) - 1) begin
          chkEq(req, "readyN mid sequence", int'(readyN), 1);
          chkEq("R11", "modeClear mid sequence", int'(modeClear), 0);
        end else begin
          chkEq(req, "readyN at end", int'(readyN), 0);
          chkEq("R11", "modeClear at end", int'(modeClear), int'(v.clr));
        end
      end
      nib = v.clr ? 4'h0 : v.seq[3:0];
      serviceStep(int'(nib[3:2]), int'(nib[1:0]), int'(ch), req);
      chkEq("R7", "regSel in sequence mode", int'(regSel), 0);
      pulseRead();
      chkEq("R9", "readyN after read", int'(readyN), 1);
    end

    // R7: coefficient access modes
    writeMode(3'd0, '0);
    serviceStep(0, 0, 0, "R2");
    chkEq("R2", "readyN low", int'(readyN), 0);
    writeMode(3'd6, '0);
    chkEq("R7", "regSel mode 110", int'(regSel), 1);
    chkEq("R7", "readyN kept in 110", int'(readyN), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chkEq("R7", "no request in 110", int'(measReq), 0);
    end
    measDone = 1'b1;
    @(negedge clk);
    measDone = 1'b0;
    @(negedge clk);
    chkEq("R8", "stray done ignored", int'(readyN), 0);
    writeMode(3'd7, '0);
    chkEq("R7", "regSel mode 111", int'(regSel), 2);
    chkEq("R7", "readyN kept in 111", int'(readyN), 0);
    @(negedge clk);
    chkEq("R7", "no request in 111", int'(measReq), 0);
    writeMode(3'd0, '0);
    chkEq("R7", "regSel back to data", int'(regSel), 0);
    chkEq("R9", "readyN released by write", int'(readyN), 1);

    // R10: done in the same cycle as a mode write is ignored
    waitReq("R10");
    modeWrData = 3'd6;
    modeWrEn   = 1'b1;
    measDone   = 1'b1;
    @(negedge clk);
    modeWrEn   = 1'b0;
    measDone   = 1'b0;
    chkEq("R10", "readyN after aborted done", int'(readyN), 1);
    chkEq("R10", "measReq after abort", int'(measReq), 0);
    chkEq("R10", "no modeClear on abort", int'(modeClear), 0);

    // R10: abort a running calibration and restart with a new mode
    writeMode(3'd1, 2'd1);
    waitReq("R10");
    chkEq("R10", "first self step kind", int'(measKind), 1);
    writeMode(3'd3, 2'd1);
    chkEq("R10", "measReq dropped by write", int'(measReq), 0);
    serviceStep(2, 0, 1, "R10");
    chkEq("R10", "readyN after new mode", int'(readyN), 0);
    chkEq("R11", "modeClear after new mode", int'(modeClear), 1);
    @(negedge clk);
    chkEq("R11", "modeClear one cycle", int'(modeClear), 0);

    // R9: completion wins over read in the same cycle
    pulseRead();
    waitReq("R9");
    measDone   = 1'b1;
    readStrobe = 1'b1;
    @(negedge clk);
    measDone   = 1'b0;
    readStrobe = 1'b0;
    chkEq("R9", "completion beats read", int'(readyN), 0);

    // R8: channel captured at request rise
    writeMode(3'd0, 2'd2);
    waitReq("R8");
    chkEq("R8", "measChan captured", int'(measChan), 2);
    chanSel = 2'd1;
    @(negedge clk);
    chkEq("R8", "measChan held", int'(measChan), 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule